// File: doc/BRIEF.md
# Protection Region Descriptor Bank

This block keeps a set of protection region descriptors in registers on a simple single-cycle register bus. Each descriptor is 128 bits, held as four 32-bit words. Rewriting a full descriptor takes four stores, and while that happens the descriptor must not be enforced half-written. So the bank drops a region's valid flag whenever any of the first three words is stored. Only a store to the last word, which carries the flag, can set it again. A second, narrower address window reaches each region's permission word by itself. Software uses it to change access rights between tasks without disturbing whether the region is enforced.

Every region's valid flag, process identifier, identifier mask and permission word are driven out as flat vectors for a downstream checker. A built-in check also reports whether an access is refused. The request names a master and an access kind, and the access is refused when no valid region grants that kind of access to that master in user mode.

Top module: `rgn_desc_bank`

## Requirements
- R1: Word k (0 to 3) of region n, for n below NUM_RGN, sits at byte offset 0x400 + 16*n + 4*k. Words 0, 1 and 2 read back all 32 bits last stored.
- R2: Word 3 reads back the process identifier in bits [31:24], the identifier mask in bits [23:16] and the valid flag in bit 0. Bits [15:1] always read as zero, whatever was written.
- R3: After reset every region's valid flag is 0, so the access check reports a refusal for any request.
- R4: A store to word 0, 1 or 2 of a region clears that region's valid flag at the same clock edge that stores the data.
- R5: A store to word 3 loads the valid flag from write-data bit 0, so it can either set or clear the flag.
- R6: A store to the alias at offset 0x800 + 4*n writes the word 2 storage of region n and leaves its valid flag unchanged. A read of the alias returns word 2.
- R7: A read of any offset outside the two windows, or of a misaligned offset (bits [1:0] not zero), returns zero. A store there changes no register and no valid flag.
- R8: Outputs rgn_valid, rgn_pid, rgn_mask and rgn_perm carry region n's valid flag, identifier, mask and word 2 in slice n.
- R9: Master m's user permission field is word 2 bits [6m+2:6m]: bit 6m+2 read, bit 6m+1 write, bit 6m execute. chk_type encodes read=0, write=1, execute=2, none=3. chk_error is 1 exactly when no valid region has the requested bit set for chk_master. Type 3 is always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for a full 32-bit store |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| chk_master | input | MST_W | Master requesting the access |
| chk_type | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| chk_error | output | 1 | 1 when no valid region grants the request |
| rgn_valid | output | NUM_RGN | Valid flag per region |
| rgn_pid | output | 8*NUM_RGN | Process identifier per region |
| rgn_mask | output | 8*NUM_RGN | Process identifier mask per region |
| rgn_perm | output | 32*NUM_RGN | Permission word (word 2) per region |

## Verification
On every cycle, the assertions check how the valid flag evolves for each region after each kind of store: it drops after a store to words 0 to 2, follows bit 0 after a store to word 3, and holds after an alias store. They also check that a store outside the windows leaves every flag unchanged, and that the access check refuses when nothing is valid or the kind is none. Only the bench scenarios can show that the correct region and word are reached from each offset, how word 3 looks when read back, and that the grant decision picks the right bit for each master and access kind.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_NONE  = 2'd3
   } acc_e;

   localparam int WORD_W     = 32;
   localparam int ID_W       = 8;
   localparam int DESC_WIN   = 1;
   localparam int ALIAS_WIN  = 2;
   localparam int PERM_SLOT  = 6;
   localparam int PID_LSB    = 24;
   localparam int MASK_LSB   = 16;

   function automatic logic [WORD_W-1:0] pack_w3(input logic [ID_W-1:0] pid,
                                                  input logic [ID_W-1:0] mask,
                                                  input logic            vld);
      logic [WORD_W-1:0] w;
      w = '0;
      w[PID_LSB +: ID_W]  = pid;
      w[MASK_LSB +: ID_W] = mask;
      w[0]                = vld;
      return w;
   endfunction
endpackage

// File: rtl/rgn_addr_dec.sv
module rgn_addr_dec
   import rgn_pkg::*;
#(
   parameter int NUM_RGN = 8,
   parameter int ADDR_W  = 12,
   parameter int RGN_W   = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              desc_hit,
   output logic              alias_hit,
   output logic [RGN_W-1:0]  idx,
   output logic [1:0]        word
);
   localparam int WIN_W = ADDR_W - 10;

   logic [WIN_W-1:0] win;
   logic [5:0]       desc_slot;
   logic [5:0]       alias_slot;
   logic             aligned;

   always_comb begin
      win        = addr[ADDR_W-1:10];
      desc_slot  = addr[9:4];
      alias_slot = addr[7:2];
      aligned    = (addr[1:0] == 2'b00);
      desc_hit   = aligned && (win == WIN_W'(DESC_WIN)) &&
                   (32'(desc_slot) < NUM_RGN);
      alias_hit  = aligned && (win == WIN_W'(ALIAS_WIN)) &&
                   (addr[9:8] == 2'b00) && (32'(alias_slot) < NUM_RGN);
      word       = addr[3:2];
      idx        = alias_hit ? alias_slot[RGN_W-1:0] : desc_slot[RGN_W-1:0];
   end
endmodule

// File: rtl/rgn_entry.sv
module rgn_entry
   import rgn_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        we_word,
   input  logic              we_alias,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] w0_q,
   output logic [WORD_W-1:0] w1_q,
   output logic [WORD_W-1:0] w2_q,
   output logic [ID_W-1:0]   pid_q,
   output logic [ID_W-1:0]   mask_q,
   output logic              vld_q
);
   logic drop_vld;

   assign drop_vld = |we_word[2:0];

   always_ff @(posedge clk) begin
      if (we_word[0]) w0_q <= wdata;
      if (we_word[1]) w1_q <= wdata;
      if (we_word[2] || we_alias) w2_q <= wdata;
      if (we_word[3]) begin
         pid_q  <= wdata[PID_LSB +: ID_W];
         mask_q <= wdata[MASK_LSB +: ID_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          vld_q <= 1'b0;
      else if (we_word[3]) vld_q <= wdata[0];
      else if (drop_vld)   vld_q <= 1'b0;
   end

   // R1
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_word, we_alias}));
   // R4
   low_word_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|we_word[2:0]) |=> !vld_q);
   // R5
   flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_word[3] |=> (vld_q == $past(wdata[0])));
   // R6
   alias_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_alias |=> (vld_q == $past(vld_q)));
endmodule

// File: rtl/rgn_access_chk.sv
module rgn_access_chk
   import rgn_pkg::*;
#(
   parameter int NUM_RGN = 8,
   parameter int NUM_MST = 2,
   parameter int MST_W   = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_RGN-1:0]        vld,
   input  logic [WORD_W*NUM_RGN-1:0] perm,
   input  logic [MST_W-1:0]          master,
   input  logic [1:0]                acc,
   output logic [NUM_RGN-1:0]        grant,
   output logic                      error
);
   logic       mst_ok;
   logic       acc_ok;
   logic [4:0] bit_ofs;

   always_comb begin
      mst_ok  = (32'(master) < NUM_MST);
      acc_ok  = (acc != ACC_NONE);
      bit_ofs = 5'(PERM_SLOT * 32'(master)) + 5'(2 - 32'(acc));
   end

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
      logic [WORD_W-1:0] word;
      assign word     = perm[r*WORD_W +: WORD_W];
      assign grant[r] = vld[r] && mst_ok && acc_ok && word[bit_ofs];
   end

   assign error = ~|grant;

   // R9
   none_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld == '0) |-> error);
   // R9
   kind_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_NONE) |-> error);
endmodule

// File: rtl/rgn_desc_bank.sv
module rgn_desc_bank
   import rgn_pkg::*;
#(
   parameter int NUM_RGN = 8,
   parameter int NUM_MST = 2,
   parameter int ADDR_W  = 12,
   localparam int MST_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_we,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               bus_rdata,
   input  logic [MST_W-1:0]          chk_master,
   input  logic [1:0]                chk_type,
   output logic                      chk_error,
   output logic [NUM_RGN-1:0]        rgn_valid,
   output logic [8*NUM_RGN-1:0]      rgn_pid,
   output logic [8*NUM_RGN-1:0]      rgn_mask,
   output logic [32*NUM_RGN-1:0]     rgn_perm
);
   localparam int RGN_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;

   if (NUM_RGN < 1 || NUM_RGN > 64) begin : g_bad_rgn
      $error("NUM_RGN must lie in 1..64");
   end
   if (NUM_MST < 1 || NUM_MST > 5) begin : g_bad_mst
      $error("NUM_MST must lie in 1..5");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end

   logic             desc_hit;
   logic             alias_hit;
   logic [RGN_W-1:0] dec_idx;
   logic [1:0]       dec_word;

   rgn_addr_dec #(
      .NUM_RGN (NUM_RGN),
      .ADDR_W  (ADDR_W),
      .RGN_W   (RGN_W)
   ) u_dec (
      .addr      (bus_addr),
      .desc_hit  (desc_hit),
      .alias_hit (alias_hit),
      .idx       (dec_idx),
      .word      (dec_word)
   );

   logic [WORD_W-1:0] w0_q   [NUM_RGN];
   logic [WORD_W-1:0] w1_q   [NUM_RGN];
   logic [WORD_W-1:0] w2_q   [NUM_RGN];
   logic [ID_W-1:0]   pid_q  [NUM_RGN];
   logic [ID_W-1:0]   mask_q [NUM_RGN];

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_ent
      logic       sel;
      logic [3:0] we_word;
      logic       we_alias;

      assign sel      = bus_we && (dec_idx == RGN_W'(r));
      assign we_word  = (sel && desc_hit) ? (4'b0001 << dec_word) : 4'b0000;
      assign we_alias = sel && alias_hit;

      rgn_entry u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .we_word  (we_word),
         .we_alias (we_alias),
         .wdata    (bus_wdata),
         .w0_q     (w0_q[r]),
         .w1_q     (w1_q[r]),
         .w2_q     (w2_q[r]),
         .pid_q    (pid_q[r]),
         .mask_q   (mask_q[r]),
         .vld_q    (rgn_valid[r])
      );

      assign rgn_pid [r*ID_W +: ID_W]     = pid_q[r];
      assign rgn_mask[r*ID_W +: ID_W]     = mask_q[r];
      assign rgn_perm[r*WORD_W +: WORD_W] = w2_q[r];
   end

   always_comb begin
      bus_rdata = '0;
      if (desc_hit) begin
         case (dec_word)
            2'd0:    bus_rdata = w0_q[dec_idx];
            2'd1:    bus_rdata = w1_q[dec_idx];
            2'd2:    bus_rdata = w2_q[dec_idx];
            default: bus_rdata = pack_w3(pid_q[dec_idx], mask_q[dec_idx],
                                         rgn_valid[dec_idx]);
         endcase
      end else if (alias_hit) begin
         bus_rdata = w2_q[dec_idx];
      end
   end

   rgn_access_chk #(
      .NUM_RGN (NUM_RGN),
      .NUM_MST (NUM_MST),
      .MST_W   (MST_W)
   ) u_chk (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (rgn_valid),
      .perm   (rgn_perm),
      .master (chk_master),
      .acc    (chk_type),
      .grant  (),
      .error  (chk_error)
   );

   // R7
   stray_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !desc_hit && !alias_hit) |=> $stable(rgn_valid));
endmodule

// File: tb/rgn_desc_bank_test.sv
module rgn_desc_bank_test;
   localparam int N  = 8;
   localparam int NM = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [0:0]  chk_master = '0;
   logic [1:0]  chk_type = 2'd3;
   logic        chk_error;
   logic [N-1:0]    rgn_valid;
   logic [8*N-1:0]  rgn_pid;
   logic [8*N-1:0]  rgn_mask;
   logic [32*N-1:0] rgn_perm;

   int total = 0;
   int bad = 0;

   logic [31:0] m_w [N][4];
   logic        m_v [N];

   always #4 clk = ~clk;

   rgn_desc_bank #(.NUM_RGN(N), .NUM_MST(NM), .ADDR_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chk_master(chk_master),
      .chk_type(chk_type), .chk_error(chk_error), .rgn_valid(rgn_valid),
      .rgn_pid(rgn_pid), .rgn_mask(rgn_mask), .rgn_perm(rgn_perm)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] d_addr(input int r, input int k);
      return 12'(32'h400 + 16*r + 4*k);
   endfunction

   function automatic logic [11:0] a_addr(input int r);
      return 12'(32'h800 + 4*r);
   endfunction

   function automatic logic [31:0] model_rd(input logic [11:0] a);
      int r;
      if (a[1:0] != 0) return 0;
      if (a >= 12'h400 && 32'(a) < 32'h400 + 16*N) begin
         r = (32'(a) - 32'h400) / 16;
         case (a[3:2])
            2'd3:    return {m_w[r][3][31:16], 15'd0, m_v[r]};
            default: return m_w[r][a[3:2]];
         endcase
      end
      if (a >= 12'h800 && 32'(a) < 32'h800 + 4*N)
         return m_w[(32'(a) - 32'h800) / 4][2];
      return 0;
   endfunction

   function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
      int r;
      if (a[1:0] != 0) return;
      if (a >= 12'h400 && 32'(a) < 32'h400 + 16*N) begin
         r = (32'(a) - 32'h400) / 16;
         m_w[r][a[3:2]] = d;
         m_v[r] = (a[3:2] == 2'd3) ? d[0] : 1'b0;
      end else if (a >= 12'h800 && 32'(a) < 32'h800 + 4*N) begin
         m_w[(32'(a) - 32'h800) / 4][2] = d;
      end
   endfunction

   function automatic logic model_err(input int m, input int t);
      for (int r = 0; r < N; r++)
         if (m_v[r] && t != 3 && m < NM && m_w[r][2][6*m + 2 - t]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      model_wr(a, d);
   endtask

   task automatic rd_chk(input logic [11:0] a, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(bus_rdata == model_rd(a), req, bus_rdata, model_rd(a));
   endtask

   task automatic acc_chk(input int m, input int t, input string req);
      @(negedge clk);
      chk_master = 1'(m); chk_type = 2'(t);
      #1;
      check(chk_error == model_err(m, t), req, 32'(chk_error), 32'(model_err(m, t)));
   endtask

   task automatic out_chk(input string req);
      @(negedge clk);
      #1;
      for (int r = 0; r < N; r++) begin
         check(rgn_valid[r] == m_v[r], req, 32'(rgn_valid[r]), 32'(m_v[r]));
         check(rgn_pid[r*8 +: 8] == m_w[r][3][31:24], req,
               32'(rgn_pid[r*8 +: 8]), 32'(m_w[r][3][31:24]));
         check(rgn_mask[r*8 +: 8] == m_w[r][3][23:16], req,
               32'(rgn_mask[r*8 +: 8]), 32'(m_w[r][3][23:16]));
         check(rgn_perm[r*32 +: 32] == m_w[r][2], req, rgn_perm[r*32 +: 32], m_w[r][2]);
      end
   endtask

   function automatic logic [11:0] stray(input int k);
      case (k % 8)
         0: return 12'h000;
         1: return 12'h3FC;
         2: return 12'(32'h400 + 16*N);
         3: return 12'h7F0;
         4: return 12'(32'h800 + 4*N);
         5: return 12'h900;
         6: return 12'hC00;
         default: return 12'h402;
      endcase
   endfunction

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
   end

   initial begin
      void'($urandom(32'h5EED1234));
      for (int r = 0; r < N; r++) begin
         m_v[r] = 1'b0;
         for (int k = 0; k < 4; k++) m_w[r][k] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3: reset state
      @(negedge clk); #1;
      check(rgn_valid == '0, "R3 valid after reset", 32'(rgn_valid), 32'd0);
      acc_chk(0, 0, "R3 refusal after reset");

      // R1 R2 R5: program every region fully
      for (int r = 0; r < N; r++) begin
         wr(d_addr(r, 0), $urandom());
         wr(d_addr(r, 1), $urandom());
         wr(d_addr(r, 2), $urandom());
         wr(d_addr(r, 3), $urandom() | 32'h0000_FFFF);
      end
      for (int r = 0; r < N; r++)
         for (int k = 0; k < 4; k++) rd_chk(d_addr(r, k), "R1 R2 readback");
      out_chk("R5 R8 outputs after programming");

      // R4: low-word store drops the flag with the data
      for (int k = 0; k < 3; k++) begin
         wr(d_addr(3, 3), 32'hA5C3_0001);
         wr(d_addr(3, k), 32'h1234_0000 + 32'(k));
         @(negedge clk); #1;
         check(rgn_valid[3] == 1'b0, "R4 flag drop", 32'(rgn_valid[3]), 32'd0);
         rd_chk(d_addr(3, k), "R4 data stored");
      end

      // R5: word 3 clears then sets
      wr(d_addr(5, 3), 32'h1122_FFFE);
      rd_chk(d_addr(5, 3), "R5 clear via word 3");
      wr(d_addr(5, 3), 32'h3344_0001);
      rd_chk(d_addr(5, 3), "R5 set via word 3");

      // R6: alias keeps validity
      wr(d_addr(6, 3), 32'h0000_0001);
      wr(a_addr(6), 32'hDEAD_BEEF);
      out_chk("R6 alias keeps flag set");
      rd_chk(d_addr(6, 2), "R6 alias writes word 2");
      rd_chk(a_addr(6), "R6 alias read");
      wr(d_addr(7, 3), 32'h0000_0000);
      wr(a_addr(7), 32'h0000_01FF);
      out_chk("R6 alias keeps flag clear");

      // R9: directed permission decode
      for (int r = 0; r < N; r++) wr(d_addr(r, 3), 32'h0);
      wr(d_addr(0, 2), 32'h0000_0080);
      wr(d_addr(0, 3), 32'h0000_0001);
      acc_chk(1, 1, "R9 master 1 write granted");
      acc_chk(1, 0, "R9 master 1 read refused");
      acc_chk(0, 1, "R9 master 0 write refused");
      acc_chk(1, 3, "R9 kind none refused");
      wr(a_addr(0), 32'h0000_0004);
      acc_chk(0, 0, "R9 master 0 read granted");
      acc_chk(0, 2, "R9 master 0 exec refused");

      // R7: stray reads and stores
      for (int k = 0; k < 8; k++) begin
         wr(stray(k), 32'hFFFF_FFFF);
         rd_chk(stray(k), "R7 stray read zero");
      end
      out_chk("R7 stray stores change nothing");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op = int'($urandom() % 8);
         int r  = int'($urandom() % N);
         case (op)
            0, 1, 2, 3: wr(d_addr(r, op), $urandom());
            4: wr(a_addr(r), $urandom());
            5: rd_chk(($urandom() % 2) ? a_addr(r) : d_addr(r, int'($urandom() % 4)),
                      "R1 R2 R6 random read");
            6: begin
                  wr(stray(int'($urandom())), $urandom());
                  rd_chk(stray(int'($urandom())), "R7 random stray");
               end
            default: acc_chk(int'($urandom() % 2), int'($urandom() % 4), "R9 random check");
         endcase
         if (i % 50 == 49) out_chk("R8 random outputs");
      end

      summary();
   end
endmodule